// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire serial bus. Its job is to free the data line after a protocol interruption, a power loss or a reset. A target device may have been stopped partway through a byte and can still be holding SDA low. The sequencer clears that state by clocking SCL with no address and no data. During the high part of every pulse it looks at SDA. As soon as it sees the line released, it stops clocking and places a start condition on the bus.

Both lines are driven only through open-drain enables: a 1 on an enable pulls that line low, and a 0 releases it. Phase lengths are parameters counted in system clocks. Their defaults meet the slowest standard bus mode when the system clock runs at 200 MHz.

After the start condition the block holds both lines low and raises `done`. The normal controller can then take the bus over with a start condition already in place. If SDA is still low after the last allowed pulse, the block releases both lines and raises `fail`. Either result is held until the request is withdrawn.

Top module: `bus_unjam_seq`

## Requirements
- R1: While reset is asserted (synchronous, active low), and in idle afterwards, both drive enables, `done` and `fail` are 0.
- R2: When a request is accepted from idle, each pulse pulls SCL low for `LOW_CYC` clocks and then releases it for `HIGH_CYC` clocks. SDA is never pulled low while SCL is being pulsed.
- R3: `sda_in` is sampled in the last clock of each SCL high phase. The first sample that reads 1 ends the pulsing, so pulse count = (number of low samples) + 1.
- R4: No more than `MAX_PULSES` SCL pulses are issued. If the sample in pulse `MAX_PULSES` still reads 0, `fail` is set to 1 and both lines are released.
- R5: After a high sample, SCL and SDA both stay released for `SETUP_CYC` more clocks (HIGH_CYC+SETUP_CYC released clocks counted from the last SCL release). SDA is then pulled low with SCL still released for `HOLD_CYC` clocks, which forms the start condition.
- R6: After the hold time, both enables are 1 and `done` is 1.
- R7: When `recover_req` is 0 at a clock edge, the block is in idle from that edge on, with lines released and both flags cleared. A request can be dropped at any point.
- R8: `done` and `fail` are never 1 together. A terminal result, done or fail, holds unchanged while the request stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| recover_req | input | 1 | Level request; withdraw to return to idle |
| sda_in | input | 1 | Synchronized sensed level of SDA |
| scl_drive_low | output | 1 | Open-drain enable; 1 pulls SCL low |
| sda_drive_low | output | 1 | Open-drain enable; 1 pulls SDA low |
| done | output | 1 | Start condition issued, bus handed over |
| fail | output | 1 | SDA still low after the last pulse |

## Verification
On every cycle the assertions check the following:
- SDA stays released whenever SCL is pulsed.
- The pulse count never exceeds the cap.
- SDA is only ever pulled low while SCL is released.
- `done` follows directly after a start hold.
- A failure leaves both lines free.
- The two flags are never set together.
- A withdrawn request empties the bus in the next cycle.

Other behaviour shows up only in the bench's scenarios, where a modelled target holds SDA low for a chosen number of pulses. Those scenarios cover the exact phase lengths, the setup and hold durations, the count at which pulsing stops, and the boundary between the ninth-pulse success and a failure.

// File: rtl/unjam_pkg.sv
// Shared types and helpers for the bus recovery sequencer.
package unjam_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOW     = 3'd1,
        ST_HIGH    = 3'd2,
        ST_SETUP   = 3'd3,
        ST_HOLD    = 3'd4,
        ST_HANDOFF = 3'd5,
        ST_FAIL    = 3'd6
    } unjam_state_t;

    // Largest of four phase lengths, used to size the shared timer.
    function automatic int longest4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/unjam_phase_timer.sv
// Down-counter for phase length. A load sets the count to (length - 1),
// and `last` is high on the final clock of the phase.
// Assumes every load value fits in W bits.
module unjam_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] count;

    // Load on phase entry, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)              count <= '0;
        else if (load)           count <= load_val;
        else if (count != '0)    count <= count - 1'b1;
    end

    assign last = (count == '0);
endmodule

// File: rtl/unjam_pulse_counter.sv
// Counts finished SCL pulses in one recovery attempt.
// `at_cap` shows that the pulse now ending is the last one allowed.
// Assumes CW bits can hold MAX_PULSES.
module unjam_pulse_counter #(
    parameter int MAX_PULSES = 9,
    parameter int CW         = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic at_cap
);
    logic [CW-1:0] pulses;

    // Clear between attempts, step once per completed high phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) pulses <= '0;
        else if (inc)        pulses <= pulses + 1'b1;
    end

    assign at_cap = (pulses == CW'(MAX_PULSES - 1));
endmodule

// File: rtl/bus_unjam_seq.sv
// Two-wire bus recovery sequencer: blind SCL pulsing, release
// detection on each high phase, then a start condition.
// Assumes sda_in is already synchronized to clk and that the lines have
// external pull-ups. Clock stretching and arbitration are not handled.
module bus_unjam_seq
    import unjam_pkg::*;
#(
    parameter int LOW_CYC    = 940,  // 4.7 us at 200 MHz
    parameter int HIGH_CYC   = 800,  // 4.0 us at 200 MHz
    parameter int SETUP_CYC  = 940,  // start setup
    parameter int HOLD_CYC   = 800,  // start hold
    parameter int MAX_PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic recover_req,
    input  logic sda_in,
    output logic scl_drive_low,
    output logic sda_drive_low,
    output logic done,
    output logic fail
);
    localparam int LONGEST = longest4(LOW_CYC, HIGH_CYC, SETUP_CYC, HOLD_CYC);
    localparam int TW      = $clog2(LONGEST) + 1;
    localparam int CW      = $clog2(MAX_PULSES + 1);

    unjam_state_t state, state_nx;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_last;
    logic          cnt_clear;
    logic          cnt_inc;
    logic          at_cap;

    unjam_phase_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    unjam_pulse_counter #(.MAX_PULSES(MAX_PULSES), .CW(CW)) u_pulses (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cnt_clear),
        .inc    (cnt_inc),
        .at_cap (at_cap)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state choice and timer reload on every phase entry.
    always_comb begin
        state_nx  = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        cnt_clear = (state == ST_IDLE);
        cnt_inc   = (state == ST_HIGH) && tmr_last;
        unique case (state)
            ST_IDLE: if (recover_req) begin
                state_nx = ST_LOW;
                tmr_load = 1'b1;
                tmr_val  = TW'(LOW_CYC - 1);
            end
            ST_LOW: if (tmr_last) begin
                state_nx = ST_HIGH;
                tmr_load = 1'b1;
                tmr_val  = TW'(HIGH_CYC - 1);
            end
            ST_HIGH: if (tmr_last) begin
                if (sda_in) begin
                    state_nx = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SETUP_CYC - 1);
                end else if (at_cap) begin
                    state_nx = ST_FAIL;
                end else begin
                    state_nx = ST_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(LOW_CYC - 1);
                end
            end
            ST_SETUP: if (tmr_last) begin
                state_nx = ST_HOLD;
                tmr_load = 1'b1;
                tmr_val  = TW'(HOLD_CYC - 1);
            end
            ST_HOLD: if (tmr_last) state_nx = ST_HANDOFF;
            ST_HANDOFF, ST_FAIL: state_nx = state;
            default: state_nx = ST_IDLE;
        endcase
        if (!recover_req) begin
            state_nx = ST_IDLE;
            tmr_load = 1'b0;
        end
    end

    // Line enables and result flags decode straight from the state register.
    assign scl_drive_low = (state == ST_LOW) || (state == ST_HANDOFF);
    assign sda_drive_low = (state == ST_HOLD) || (state == ST_HANDOFF);
    assign done          = (state == ST_HANDOFF);
    assign fail          = (state == ST_FAIL);
endmodule

// File: rtl/unjam_checker.sv
// Protocol checker for bus_unjam_seq. It watches ports only and
// keeps its own count of SCL pulses for the cap check.
module unjam_checker #(
    parameter int MAX_PULSES = 9
) (
    input logic clk,
    input logic rst_n,
    input logic recover_req,
    input logic scl_drive_low,
    input logic sda_drive_low,
    input logic done,
    input logic fail
);
    localparam int PW = $clog2(MAX_PULSES + 2) + 1;

    logic          scl_prev;
    logic [PW-1:0] seen;

    // Count each new SCL low drive issued while SDA is free.
    always_ff @(posedge clk) begin
        if (!rst_n || !recover_req) begin
            scl_prev <= 1'b0;
            seen     <= '0;
        end else begin
            scl_prev <= scl_drive_low;
            if (scl_drive_low && !scl_prev && !sda_drive_low)
                seen <= seen + 1'b1;
        end
    end

    AST_SDA_FREE_WHILE_PULSING: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_drive_low && !done) |-> !sda_drive_low);                      // R2
    AST_PULSE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        seen <= PW'(MAX_PULSES));                                           // R4
    AST_FAIL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (!scl_drive_low && !sda_drive_low));                       // R4
    AST_START_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> !scl_drive_low);                           // R5
    AST_DONE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(sda_drive_low) && !$past(scl_drive_low)));   // R6
    AST_WITHDRAW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !recover_req |=> (!scl_drive_low && !sda_drive_low && !done && !fail)); // R7
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));                                                   // R8
endmodule

bind bus_unjam_seq unjam_checker #(.MAX_PULSES(MAX_PULSES)) u_unjam_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .recover_req   (recover_req),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .done          (done),
    .fail          (fail)
);

// File: tb/bus_unjam_seq_bench.sv
// Bench: a modelled target holds SDA low for K pulses, driven from a vector table.
module bus_unjam_seq_bench;
    localparam int LOW_C = 5, HIGH_C = 4, SETUP_C = 6, HOLD_C = 3, MAXP = 9;
    localparam int NV = 5;
    localparam int VEC_K    [NV] = '{0, 3, 8, 9, 20};
    localparam int VEC_P    [NV] = '{1, 4, 9, 9, 9};
    localparam bit VEC_FAIL [NV] = '{0, 0, 0, 1, 1};

    logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
    logic scl_o, sda_o, done, fail;
    int   slave_hold = 1000;
    int   pulses = 0;
    int   total = 0, bad = 0;
    logic sda_line;

    always #2.5 clk = ~clk;

    assign sda_line = !sda_o && (pulses > slave_hold);

    bus_unjam_seq #(.LOW_CYC(LOW_C), .HIGH_CYC(HIGH_C), .SETUP_CYC(SETUP_C),
                    .HOLD_CYC(HOLD_C), .MAX_PULSES(MAXP)) u_bus_unjam_seq (
        .clk(clk), .rst_n(rst_n), .recover_req(req), .sda_in(sda_line),
        .scl_drive_low(scl_o), .sda_drive_low(sda_o), .done(done), .fail(fail));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_case(input int k, input int exp_p, input bit exp_f);
        logic [1:0] code, prev_code;
        int run = 0, first_low = -1, first_high = -1, setup_seen = -1, hold_seen = -1;
        bit finished = 0;
        slave_hold = k;
        pulses = 0;
        prev_code = 2'b00;
        @(negedge clk) req = 1'b1;
        for (int c = 0; c < 3000 && !finished; c++) begin
            @(negedge clk);
            code = {scl_o, sda_o};
            if (code == prev_code) run++;
            else begin
                if (prev_code == 2'b10 && first_low < 0) first_low = run;
                if (prev_code == 2'b00 && code == 2'b10 && pulses >= 1 && first_high < 0)
                    first_high = run;
                if (prev_code == 2'b00 && code == 2'b01) setup_seen = run;
                if (prev_code == 2'b01 && code == 2'b11) hold_seen = run;
                if (code == 2'b10) pulses++;
                run = 1;
            end
            prev_code = code;
            if (done || fail) finished = 1;
        end
        chk(first_low == LOW_C, "R2 low phase length", first_low, LOW_C);
        if (k >= 1) chk(first_high == HIGH_C, "R2 high phase length", first_high, HIGH_C);
        if (exp_f) chk(pulses == exp_p, "R4 pulse cap", pulses, exp_p);
        else       chk(pulses == exp_p, "R3 stop on first release", pulses, exp_p);
        chk(fail == exp_f, "R4 fail flag", int'(fail), int'(exp_f));
        chk(done == !exp_f, "R6 done flag", int'(done), int'(!exp_f));
        if (!exp_f) begin
            chk(setup_seen == HIGH_C + SETUP_C, "R5 released before start",
                setup_seen, HIGH_C + SETUP_C);
            chk(hold_seen == HOLD_C, "R5 start hold", hold_seen, HOLD_C);
            chk(scl_o && sda_o, "R6 both lines held low", int'({scl_o, sda_o}), 3);
        end else begin
            chk(!scl_o && !sda_o, "R4 lines released on fail", int'({scl_o, sda_o}), 0);
        end
        repeat (10) @(negedge clk);
        chk(done == !exp_f && fail == exp_f && !(done && fail), "R8 result held",
            int'({done, fail}), exp_f ? 1 : 2);
        req = 1'b0;
        @(negedge clk);
        chk({scl_o, sda_o, done, fail} == 4'b0, "R7 withdraw to idle",
            int'({scl_o, sda_o, done, fail}), 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk({scl_o, sda_o, done, fail} == 4'b0, "R1 reset state",
            int'({scl_o, sda_o, done, fail}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({scl_o, sda_o, done, fail} == 4'b0, "R1 idle without request",
            int'({scl_o, sda_o, done, fail}), 0);

        for (int v = 0; v < NV; v++) run_case(VEC_K[v], VEC_P[v], VEC_FAIL[v]);

        // R7: abort partway through pulsing
        slave_hold = 1000;
        pulses = 0;
        @(negedge clk) req = 1'b1;
        repeat (8) @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        chk({scl_o, sda_o, done, fail} == 4'b0, "R7 abort mid pulse",
            int'({scl_o, sda_o, done, fail}), 0);

        // R1: reset partway through pulsing
        @(negedge clk) req = 1'b1;
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({scl_o, sda_o, done, fail} == 4'b0, "R1 reset mid sequence",
            int'({scl_o, sda_o, done, fail}), 0);
        req = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule